// File: doc/BRIEF.md
# Nine-Bit Single-Cycle Processor Core

This core runs programs made of fixed 9-bit instructions. It fetches them from an instruction memory and reads and writes bytes in a separate data memory, one instruction per clock. Both memories sit outside the core and have combinational reads. The data memory takes one write per clock.

There are eight 8-bit registers. Register 7 is the result register: every computing instruction writes its result there. A move instruction copies values out of it into the other registers. The instruction set has eight operations. The only logic operation is NAND, and a rotate takes its amount from a register. A conditional branch finds its destination through an 8-entry table of full addresses, so a short index field in the instruction is enough to reach any address.

After reset the core waits for a start pulse. It then runs until the program counter reaches a reserved halt address. At that point it raises its halt flag and freezes until the next reset.

Top module: `tiny9_core`

## Requirements
- R1: Under reset and after it, until a start pulse arrives, the fetch address is 0, halt_o is 0 and no data write occurs.
- R2: Once started, the core executes one instruction per clock. Every instruction other than a taken branch advances the fetch address by one.
- R3: The opcode is in bits [8:6], the first register field ra in [5:3] and the second field rb in [2:0]. The codes are: 0 NAND, 1 load, 2 store, 3 rotate, 4 move, 5 add, 6 branch, 7 set. Set (7) writes its 6-bit immediate in bits [5:0], zero-extended, into register 7.
- R4: NAND (0) writes ~(R[ra] & R[rb]) into register 7.
- R5: Add (5) writes (R[ra] + R[rb]) mod 256 into register 7.
- R6: Rotate (3) writes R[ra] rotated right by R[rb][2:0] into register 7. Bits shifted out at the bottom re-enter at the top.
- R7: Load (1) writes the byte at data address R[rb] into register 7. Store (2) writes R[ra] to data address R[rb], with a one-cycle strobe, and changes no register. Only store raises the write strobe.
- R8: Move (4) copies R[rb] into R[ra] and leaves register 7 unchanged unless ra is 7.
- R9: Branch (6) compares R0 with R1. When they are equal, the next fetch address is table entry [2:0]; otherwise it is the next address. The default table holds 0, 16, 32, 48, 64, 80, 96 and 1023 for indices 0 to 7.
- R10: When the fetch address equals HALT_ADDR (default 1023), the instruction there is not executed, and halt_o rises one clock later.
- R11: After halt, the fetch address, registers and data memory stay frozen and start pulses are ignored until reset.
- R12: A start pulse during a run has no effect on the program flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; begins execution at address 0 |
| imem_addr_o | output | ADDR_W | Instruction fetch address (program counter) |
| imem_data_i | input | 9 | Instruction at the fetch address |
| dmem_addr_o | output | ADDR_W | Data memory address |
| dmem_wdata_o | output | DATA_W | Data memory write data |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | DATA_W | Data memory read data |
| halt_o | output | 1 | Program finished; core frozen |

## Verification
Two things can happen in the same cycle. A taken branch can select the halt address as its destination, and the halt check then resolves on the next fetch. The bench provokes this by ending its branch program with a branch to table entry 7. It judges the result by the exact cycle on which halt rises, and by the absence of any write from the code placed after that branch. A start pulse can also arrive while instructions are executing. The bench injects one mid-run and checks that neither the halt timing nor the number of stores changes.

// File: rtl/tiny9_pkg.sv
package tiny9_pkg;
  localparam int INSN_W     = 9;
  localparam int OPC_W      = 3;
  localparam int RIDX_W     = 3;
  localparam int IMM_W      = 6;
  localparam int NREG       = 1 << RIDX_W;
  localparam int OUT_REG    = NREG - 1;
  localparam int BR_IDX_W   = 3;
  localparam int BR_ENTRIES = 1 << BR_IDX_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NAND = 3'd0,
    OP_LDR  = 3'd1,
    OP_STR  = 3'd2,
    OP_ROR  = 3'd3,
    OP_MOV  = 3'd4,
    OP_ADD  = 3'd5,
    OP_BEQ  = 3'd6,
    OP_SET  = 3'd7
  } opcode_e;

  typedef struct packed {
    opcode_e           op;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
  } insn_t;

  typedef struct packed {
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic              dmem_we;
    logic              branch;
  } ctrl_t;
endpackage

// File: rtl/tiny9_decode.sv
module tiny9_decode
  import tiny9_pkg::*;
(
  input  insn_t insn_i,
  input  logic  exec_en_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.rf_waddr = RIDX_W'(OUT_REG);
    if (exec_en_i) begin
      unique case (insn_i.op)
        OP_NAND, OP_LDR, OP_ROR, OP_ADD, OP_SET: ctrl_o.rf_we = 1'b1;
        OP_MOV: begin
          ctrl_o.rf_we    = 1'b1;
          ctrl_o.rf_waddr = insn_i.ra;
        end
        OP_STR:  ctrl_o.dmem_we = 1'b1;
        OP_BEQ:  ctrl_o.branch  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tiny9_regfile.sv
module tiny9_regfile
  import tiny9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RIDX_W-1:0] raddr_a_i,
  input  logic [RIDX_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [DATA_W-1:0] r0_o,
  output logic [DATA_W-1:0] r1_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && waddr_i == RIDX_W'(g))      regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign r0_o      = regs_q[0];
  assign r1_o      = regs_q[1];
endmodule

// File: rtl/tiny9_alu.sv
module tiny9_alu
  import tiny9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] rot;

  assign sh  = b_i[SH_W-1:0];
  // amount 0 gives a << DATA_W == 0, so no special case
  assign rot = (a_i >> sh) | (a_i << (DATA_W - int'(sh)));

  always_comb begin
    unique case (op_i)
      OP_NAND: res_o = ~(a_i & b_i);
      OP_LDR:  res_o = mem_i;
      OP_ROR:  res_o = rot;
      OP_MOV:  res_o = b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SET:  res_o = DATA_W'(imm_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/tiny9_fetch.sv
module tiny9_fetch
  import tiny9_pkg::*;
#(
  parameter int                             ADDR_W    = 10,
  parameter logic [ADDR_W-1:0]              HALT_ADDR = '1,
  parameter logic [BR_ENTRIES*ADDR_W-1:0]   BR_TABLE  = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                taken_i,
  input  logic [BR_IDX_W-1:0] br_idx_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic                exec_en_o,
  output logic                halt_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic              at_end;

  assign at_end    = (pc_q == HALT_ADDR);
  assign exec_en_o = (state_q == ST_RUN) && !at_end;
  assign halt_o    = (state_q == ST_HALT);
  assign pc_o      = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_RUN;
        ST_RUN: begin
          if (at_end)       state_q <= ST_HALT;
          else if (taken_i) pc_q <= BR_TABLE[br_idx_i*ADDR_W +: ADDR_W];
          else              pc_q <= pc_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tiny9_core.sv
module tiny9_core
  import tiny9_pkg::*;
#(
  parameter int                           ADDR_W    = 10,
  parameter int                           DATA_W    = 8,
  parameter logic [ADDR_W-1:0]            HALT_ADDR = '1,
  parameter logic [BR_ENTRIES*ADDR_W-1:0] BR_TABLE  = {10'd1023, 10'd96, 10'd80, 10'd64,
                                                       10'd48,   10'd32, 10'd16, 10'd0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [INSN_W-1:0] imem_data_i,
  output logic [ADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  output logic              dmem_we_o,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  output logic              halt_o
);
  insn_t             insn;
  ctrl_t             ctrl;
  logic              exec_en;
  logic              taken;
  logic [DATA_W-1:0] op_a, op_b, r0, r1, result;

  assign insn = insn_t'(imem_data_i);

  tiny9_fetch #(
    .ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR), .BR_TABLE(BR_TABLE)
  ) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .taken_i   (taken),
    .br_idx_i  (insn.rb),
    .pc_o      (imem_addr_o),
    .exec_en_o (exec_en),
    .halt_o    (halt_o)
  );

  tiny9_decode u_dec (
    .insn_i    (insn),
    .exec_en_i (exec_en),
    .ctrl_o    (ctrl)
  );

  tiny9_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl.rf_we),
    .waddr_i   (ctrl.rf_waddr),
    .wdata_i   (result),
    .raddr_a_i (insn.ra),
    .raddr_b_i (insn.rb),
    .rdata_a_o (op_a),
    .rdata_b_o (op_b),
    .r0_o      (r0),
    .r1_o      (r1)
  );

  tiny9_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (insn.op),
    .a_i   (op_a),
    .b_i   (op_b),
    .imm_i (imem_data_i[IMM_W-1:0]),
    .mem_i (dmem_rdata_i),
    .res_o (result)
  );

  assign taken        = ctrl.branch && (r0 == r1);
  assign dmem_addr_o  = ADDR_W'(op_b);
  assign dmem_wdata_o = op_a;
  assign dmem_we_o    = ctrl.dmem_we;
endmodule

// File: rtl/tiny9_core_chk.sv
module tiny9_core_chk #(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] HALT_ADDR = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_o,
  input logic              exec_en,
  input logic              dmem_we_o,
  input logic [2:0]        opcode_i,
  input logic [ADDR_W-1:0] imem_addr_o
);
  p_seq_pc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en && opcode_i != 3'd6 |=> imem_addr_o == ADDR_W'($past(imem_addr_o) + 1'b1));

  p_store_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> opcode_i == 3'd2);

  p_halt_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(imem_addr_o) == HALT_ADDR);

  p_halt_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  p_pc_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(imem_addr_o));

  p_no_exec_halted_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !exec_en && !dmem_we_o);
endmodule

bind tiny9_core tiny9_core_chk #(.ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_o      (halt_o),
  .exec_en     (exec_en),
  .dmem_we_o   (dmem_we_o),
  .opcode_i    (imem_data_i[8:6]),
  .imem_addr_o (imem_addr_o)
);

// File: tb/tiny9_core_tb_top.sv
module tiny9_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  localparam logic [2:0] NAND = 3'd0, LDR = 3'd1, STR = 3'd2, ROR = 3'd3,
                         MOV  = 3'd4, ADD = 3'd5, BEQ = 3'd6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] imem_addr, dmem_addr;
  logic [8:0]    imem_data;
  logic [DW-1:0] dmem_wdata, dmem_rdata;
  logic          dmem_we, halt;

  logic [8:0]    imem [1024];
  logic [DW-1:0] dmem [1024];
  int            wr_hits [1024];
  int            wr_total;
  int            n_chk = 0, n_bad = 0, wp = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tiny9_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_rdata_i(dmem_rdata), .halt_o(halt)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk_i) if (dmem_we) begin
    dmem[dmem_addr]    <= dmem_wdata;
    wr_hits[dmem_addr] <= wr_hits[dmem_addr] + 1;
  end

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      wr_total <= 0;
    else if (dmem_we) wr_total <= wr_total + 1;

  function automatic logic [8:0] ri(input logic [2:0] op, input int a, input int b);
    return {op, 3'(a), 3'(b)};
  endfunction
  function automatic logic [8:0] si(input int v);
    return {3'd7, 6'(v)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) imem[i] = si(0);
    wp = 0;
  endtask
  task automatic emit(input logic [8:0] ins);
    imem[wp] = ins;
    wp++;
  endtask

  task automatic run_prog(input int glitch_at, output int cycles);
    rst_ni = 1'b0; start_i = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
    cycles = 0;
    while (!halt && cycles < 3000) begin
      @(posedge clk_i); #1;
      cycles++;
      start_i = (cycles == glitch_at);
    end
    start_i = 1'b0;
  endtask

  task automatic store_out(input int src, input int addr);
    emit(si(addr)); emit(ri(MOV, 6, 7)); emit(ri(STR, src, 6));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 1'b0;
    repeat (2) @(posedge clk_i); #1;
    chk("R1 addr in reset", int'(imem_addr), 0);
    chk("R1 halt in reset", int'(halt), 0);
    chk("R1 we in reset", int'(dmem_we), 0);
    rst_ni = 1'b1;
    repeat (5) @(posedge clk_i); #1;
    chk("R1 addr idle w/o start", int'(imem_addr), 0);
    chk("R1 no writes idle", wr_total, 0);
  endtask

  task automatic t_alu();
    int n;
    clear_prog();
    emit(si(45)); emit(ri(MOV, 1, 7)); emit(si(58)); emit(ri(MOV, 2, 7));
    emit(ri(ADD, 1, 2)); emit(ri(MOV, 3, 7)); store_out(3, 10);
    emit(ri(NAND, 1, 2)); emit(ri(MOV, 3, 7)); store_out(3, 11);
    emit(ri(ROR, 1, 2)); emit(ri(MOV, 3, 7)); store_out(3, 12);
    emit(ri(NAND, 1, 2)); emit(ri(MOV, 3, 7)); emit(ri(ADD, 3, 3));
    emit(ri(MOV, 4, 7)); store_out(4, 13);
    emit(si(63)); emit(ri(MOV, 5, 7)); store_out(5, 14);
    emit(si(0)); emit(ri(MOV, 2, 7)); emit(ri(ROR, 1, 2)); emit(ri(MOV, 3, 7)); store_out(3, 15);
    emit(si(9)); emit(ri(MOV, 2, 7)); emit(ri(ROR, 1, 2)); emit(ri(MOV, 3, 7)); store_out(3, 16);
    run_prog(-1, n);
    chk("R5 add", int'(dmem[10]), 103);
    chk("R4 nand", int'(dmem[11]), 215);
    chk("R6 rotate by 2", int'(dmem[12]), 75);
    chk("R5 add wraps", int'(dmem[13]), 174);
    chk("R3 set max imm", int'(dmem[14]), 63);
    chk("R6 rotate by 0", int'(dmem[15]), 45);
    chk("R6 rotate uses low bits", int'(dmem[16]), 150);
    chk("R2 R10 sequential halt cycle", n, 1024);
  endtask

  task automatic t_mem_move();
    int n;
    clear_prog();
    emit(si(20)); emit(ri(MOV, 6, 7)); emit(si(33)); emit(ri(STR, 7, 6));
    emit(si(0)); emit(ri(LDR, 0, 6)); emit(ri(MOV, 2, 7));
    emit(si(21)); emit(ri(MOV, 6, 7)); emit(ri(STR, 2, 6));
    emit(si(22)); emit(ri(MOV, 5, 7)); emit(si(50)); emit(ri(MOV, 4, 5));
    emit(ri(STR, 7, 5));
    run_prog(5, n);
    chk("R7 store", int'(dmem[20]), 33);
    chk("R7 load", int'(dmem[21]), 33);
    chk("R8 move keeps r7", int'(dmem[22]), 50);
    chk("R7 R12 write count", wr_total, 3);
    chk("R12 start mid-run ignored", n, 1024);
  endtask

  task automatic t_branch();
    int n, w;
    clear_prog();
    emit(si(5)); emit(ri(MOV, 0, 7)); emit(si(6)); emit(ri(MOV, 1, 7));
    emit(ri(BEQ, 0, 2));
    emit(si(30)); emit(ri(MOV, 6, 7)); emit(si(1)); emit(ri(STR, 7, 6));
    emit(si(5)); emit(ri(MOV, 1, 7)); emit(ri(BEQ, 0, 2));
    emit(si(31)); emit(ri(MOV, 6, 7)); emit(si(2)); emit(ri(STR, 7, 6));
    wp = 32;
    emit(si(31)); emit(ri(MOV, 6, 7)); emit(si(3)); emit(ri(STR, 7, 6));
    emit(ri(BEQ, 0, 7));
    emit(si(32)); emit(ri(MOV, 6, 7)); emit(si(9)); emit(ri(STR, 7, 6));
    run_prog(-1, n);
    chk("R9 not taken falls through", int'(dmem[30]), 1);
    chk("R9 taken target data", int'(dmem[31]), 3);
    chk("R9 skipped store", wr_hits[31], 1);
    chk("R9 R10 code after exit branch", wr_hits[32], 0);
    chk("R10 halt cycle after branch", n, 18);
    // R11: frozen after halt, start ignored
    w = wr_total;
    @(posedge clk_i); #1 start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
    repeat (4) @(posedge clk_i); #1;
    chk("R11 pc frozen", int'(imem_addr), 1023);
    chk("R11 halt held", int'(halt), 1);
    chk("R11 no writes", wr_total, w);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) wr_hits[i] = 0;
    t_reset();
    t_alu();
    t_mem_move();
    t_branch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule